// File: doc/BRIEF.md
# Power and Fault Mode Sequencer

This block decides which operating mode a mixed-signal device is in: hardware shutdown, software shutdown, active, or a clock-fault shutdown state that waits for the clocks to recover. It watches a main-supply-valid flag, a shutdown pin, a software-written mode field and four fault flags. These are power-stage undervoltage, clock error, over-temperature and over-current. From them it drives a global reset, an analog power-down control, a resume strobe for the volume ramp, and one-cycle fault event pulses for an interrupt block.

Supply loss takes effect at once: the global reset follows the supply flag combinationally, and the mode falls to hardware shutdown at the next edge. The shutdown pin and the four fault flags come from other domains, so each passes through a two-flop synchroniser first.

An undervoltage fault, or a failed attempt to go active while undervoltage is present, latches a flag and locks out re-entry. Two things end the lockout: the flag is cleared and software writes a shutdown code, or the block passes through hardware shutdown. Over-temperature and over-current also lock out re-entry but raise no undervoltage flag. A clock error is the one fault that recovers on its own: when it clears, the block returns to active and pulses the resume strobe.

Top module: `pwr_fault_seq`

## Requirements
- R1: While `supply_ok_i` is low, `sys_rst_o` is 1 in the same cycle, and `state_o` is 0 (hardware shutdown) from the next clock edge on; `rst_n` low also forces state 0.
- R2: The block leaves hardware shutdown (state 0) for software shutdown (state 1) only when the supply is valid and the synchronised `shdn_n_i` is 1; a synchronised low on `shdn_n_i` forces state 0 from any state.
- R3: From state 1, `mode_i` = 3'b000 with no latched flag, no lockout and no fault moves to active (state 2); `ana_pd_o` is 0 only in state 2.
- R4: Undervoltage while active moves to state 1, pulses `evt_o[0]` for one cycle and sets `uv_flag_o`.
- R5: A request for active (`mode_i` = 3'b000) in state 1 while undervoltage is present keeps state 1, pulses `evt_o[0]` and sets `uv_flag_o`.
- R6: After an undervoltage, over-temperature or over-current event, entry to active is refused until two things hold together in state 1: `uv_flag_o` is 0 (cleared by `irq_clr_i`, with a set winning over a clear), and `mode_i` is not 3'b000. A pass through state 0 also clears both the flag and the lockout.
- R7: A clock error while active, with no other fault, moves to clock-fault shutdown (state 3) and pulses `evt_o[1]`.
- R8: In state 3 with `mode_i` = 3'b000, once the clock error clears and no other fault is present, the block returns to state 2 and `resume_o` is 1 for exactly one cycle.
- R9: Over-temperature or over-current while active moves to state 1 and pulses `evt_o[2]` or `evt_o[3]` respectively; `uv_flag_o` stays 0.
- R10: Any `mode_i` code other than 3'b000 counts as software shutdown: in state 2 it moves to state 1 with no event pulse.
- R11: A change on `shdn_n_i` or on a fault input reaches `state_o` at the third rising edge after it, because of the two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok_i | input | 1 | Main supply valid flag |
| shdn_n_i | input | 1 | Shutdown pin, 1 = released (asynchronous) |
| mode_i | input | 3 | Requested mode, 000 = active, anything else = software shutdown |
| irq_clr_i | input | 1 | Clears the undervoltage interrupt flag |
| uv_i | input | 1 | Power-stage undervoltage (asynchronous) |
| clk_err_i | input | 1 | Clock error: bad ratio, bad frame rate or halted clock (asynchronous) |
| ot_i | input | 1 | Over-temperature fault (asynchronous) |
| oc_i | input | 1 | Over-current fault (asynchronous) |
| sys_rst_o | output | 1 | Global reset, 1 while supply invalid |
| ana_pd_o | output | 1 | Analog power-down, 0 only in active |
| resume_o | output | 1 | One-cycle strobe to resume the volume ramp |
| evt_o | output | 4 | Fault event pulses: bit0 undervoltage, bit1 clock, bit2 over-temperature, bit3 over-current |
| uv_flag_o | output | 1 | Latched undervoltage interrupt flag |
| state_o | output | 2 | Mode: 0 hardware shutdown, 1 software shutdown, 2 active, 3 clock-fault shutdown |

## Verification
The assertions check four rules on every cycle. Supply loss always lands in hardware shutdown. A latched undervoltage flag keeps the block out of active. Undervoltage and clock errors in active take their defined exits. The resume strobe fires only on a return from clock-fault shutdown. The lockout handshake needs whole scenarios to show it: the flag clear and the mode rewrite must happen in the right order, and a pass through hardware shutdown must clear the lockout. So do the three-edge synchroniser latency and the release of the clock-fault state. The bench covers these by running directed sequences and a cycle-accurate reference model against random input traffic.

// File: rtl/pfs_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the power and fault mode sequencer.
package pfs_pkg;
    typedef enum logic [1:0] {
        ST_HWSD = 2'd0,
        ST_SWSD = 2'd1,
        ST_ACT  = 2'd2,
        ST_CKSD = 2'd3
    } pfs_state_e;

    localparam int          MODE_W      = 3;
    localparam logic [2:0]  MODE_ACTIVE = 3'b000;

    // event bit positions
    localparam int EV_UV = 0;
    localparam int EV_CK = 1;
    localparam int EV_OT = 2;
    localparam int EV_OC = 3;
    localparam int EV_W  = 4;

    // synchroniser lane positions
    localparam int SY_SHDN = 0;
    localparam int SY_UV   = 1;
    localparam int SY_CK   = 2;
    localparam int SY_OT   = 3;
    localparam int SY_OC   = 4;
    localparam int SY_W    = 5;
endpackage

// File: rtl/pfs_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchroniser for a bundle of independent level signals.
// Assumes each lane is a slow level that is held for several cycles; lanes
// are not kept coherent with each other. Reset drives every stage to 0.
module pfs_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first stage samples the asynchronous inputs
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d_i;
            end
        end else begin : g_next
            // later stages resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pfs_lock.sv
`timescale 1ns/1ps
// Undervoltage flag and re-entry lockout register.
// The flag is set by the sequencer and cleared by software. The arm bit is
// dropped on any latching fault and restored only when, in software
// shutdown, the mode field no longer asks for active and the flag is clear.
// Hardware shutdown clears the flag and re-arms.
module pfs_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic in_hwsd_i,
    input  logic in_swsd_i,
    input  logic mode_sw_i,
    input  logic irq_clr_i,
    input  logic set_uv_i,
    input  logic disarm_i,
    output logic uv_flag_o,
    output logic armed_o
);
    logic uv_flag_q;
    logic armed_q;

    // latched undervoltage interrupt flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n || in_hwsd_i) uv_flag_q <= 1'b0;
        else if (set_uv_i)       uv_flag_q <= 1'b1;
        else if (irq_clr_i)      uv_flag_q <= 1'b0;
    end

    // re-entry permission, needs flag clear plus a shutdown code written
    always_ff @(posedge clk) begin
        if (!rst_n || in_hwsd_i)                          armed_q <= 1'b1;
        else if (disarm_i)                                armed_q <= 1'b0;
        else if (in_swsd_i && mode_sw_i && !uv_flag_q)    armed_q <= 1'b1;
    end

    assign uv_flag_o = uv_flag_q;
    assign armed_o   = armed_q;
endmodule

// File: rtl/pfs_fsm.sv
`timescale 1ns/1ps
// Mode state machine. Inputs other than supply and mode are already
// synchronised. Supply loss or a held shutdown pin overrides everything.
// Event and resume outputs are registered with the state change.
module pfs_fsm
    import pfs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            supply_ok_i,
    input  logic            shdn_ok_i,
    input  logic            mode_act_i,
    input  logic            uv_i,
    input  logic            ck_i,
    input  logic            ot_i,
    input  logic            oc_i,
    input  logic            armed_i,
    input  logic            uv_flag_i,
    output pfs_state_e      state_o,
    output logic [EV_W-1:0] evt_o,
    output logic            resume_o,
    output logic            set_uv_o,
    output logic            disarm_o
);
    pfs_state_e      state_q, state_d;
    logic [EV_W-1:0] evt_q, evt_d;
    logic            resume_q, resume_d;
    logic            hard_fault;

    assign hard_fault = uv_i || ot_i || oc_i;

    // next-state and event decode with supply and pin taking priority
    always_comb begin
        state_d  = state_q;
        evt_d    = '0;
        resume_d = 1'b0;
        set_uv_o = 1'b0;
        disarm_o = 1'b0;
        if (!supply_ok_i || !shdn_ok_i) begin
            state_d = ST_HWSD;
        end else begin
            unique case (state_q)
                ST_HWSD: state_d = ST_SWSD;
                ST_SWSD: begin
                    if (mode_act_i && armed_i && !uv_flag_i) begin
                        if (uv_i) begin
                            evt_d[EV_UV] = 1'b1;
                            set_uv_o     = 1'b1;
                            disarm_o     = 1'b1;
                        end else if (!(ck_i || ot_i || oc_i)) begin
                            state_d = ST_ACT;
                        end
                    end
                end
                ST_ACT: begin
                    if (hard_fault) begin
                        state_d = ST_SWSD;
                        evt_d   = {oc_i, ot_i, ck_i, uv_i};
                        set_uv_o = uv_i;
                        disarm_o = 1'b1;
                    end else if (ck_i) begin
                        state_d      = ST_CKSD;
                        evt_d[EV_CK] = 1'b1;
                    end else if (!mode_act_i) begin
                        state_d = ST_SWSD;
                    end
                end
                ST_CKSD: begin
                    if (!mode_act_i) begin
                        state_d = ST_SWSD;
                    end else if (hard_fault) begin
                        state_d  = ST_SWSD;
                        evt_d    = {oc_i, ot_i, 1'b0, uv_i};
                        set_uv_o = uv_i;
                        disarm_o = 1'b1;
                    end else if (!ck_i) begin
                        state_d  = ST_ACT;
                        resume_d = 1'b1;
                    end
                end
            endcase
        end
    end

    // state, event and resume registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HWSD;
            evt_q    <= '0;
            resume_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            evt_q    <= evt_d;
            resume_q <= resume_d;
        end
    end

    assign state_o  = state_q;
    assign evt_o    = evt_q;
    assign resume_o = resume_q;

    // R1: supply loss lands in hardware shutdown at the next edge
    a_r1_supply_loss_hwsd: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> state_q == ST_HWSD);

    // R6: a latched flag keeps the block out of active
    a_r6_flag_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWSD && uv_flag_i) |=> state_q != ST_ACT);

    // R4: undervoltage in active exits to software shutdown with flag set
    a_r4_uv_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACT && uv_i && supply_ok_i && shdn_ok_i)
        |=> (state_q == ST_SWSD && uv_flag_i && evt_q[EV_UV]));

    // R7: a lone clock error in active enters clock-fault shutdown
    a_r7_clock_error_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACT && ck_i && !hard_fault && supply_ok_i && shdn_ok_i)
        |=> state_q == ST_CKSD);

    // R8: resume strobe only on a return from clock-fault shutdown
    a_r8_resume_source: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |-> (state_q == ST_ACT && $past(state_q) == ST_CKSD));
endmodule

// File: rtl/pwr_fault_seq.sv
`timescale 1ns/1ps
// Top of the power and fault mode sequencer. Synchronises the pin and
// fault inputs, runs the mode state machine and holds the undervoltage
// lockout. Supply valid and the mode field are assumed synchronous to clk;
// supply loss drives the global reset combinationally.
module pwr_fault_seq
    import pfs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok_i,
    input  logic              shdn_n_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              irq_clr_i,
    input  logic              uv_i,
    input  logic              clk_err_i,
    input  logic              ot_i,
    input  logic              oc_i,
    output logic              sys_rst_o,
    output logic              ana_pd_o,
    output logic              resume_o,
    output logic [EV_W-1:0]   evt_o,
    output logic              uv_flag_o,
    output logic [1:0]        state_o
);
    logic [SY_W-1:0] raw, syn;
    pfs_state_e      st;
    logic            mode_act, armed, uv_flag, set_uv, disarm;

    assign raw[SY_SHDN] = shdn_n_i;
    assign raw[SY_UV]   = uv_i;
    assign raw[SY_CK]   = clk_err_i;
    assign raw[SY_OT]   = ot_i;
    assign raw[SY_OC]   = oc_i;
    assign mode_act     = (mode_i == MODE_ACTIVE);

    pfs_sync #(.W(SY_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    pfs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok_i),
        .shdn_ok_i   (syn[SY_SHDN]),
        .mode_act_i  (mode_act),
        .uv_i        (syn[SY_UV]),
        .ck_i        (syn[SY_CK]),
        .ot_i        (syn[SY_OT]),
        .oc_i        (syn[SY_OC]),
        .armed_i     (armed),
        .uv_flag_i   (uv_flag),
        .state_o     (st),
        .evt_o       (evt_o),
        .resume_o    (resume_o),
        .set_uv_o    (set_uv),
        .disarm_o    (disarm)
    );

    pfs_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_hwsd_i (st == ST_HWSD),
        .in_swsd_i (st == ST_SWSD),
        .mode_sw_i (!mode_act),
        .irq_clr_i (irq_clr_i),
        .set_uv_i  (set_uv),
        .disarm_i  (disarm),
        .uv_flag_o (uv_flag),
        .armed_o   (armed)
    );

    assign sys_rst_o = !supply_ok_i;
    assign ana_pd_o  = (st != ST_ACT);
    assign uv_flag_o = uv_flag;
    assign state_o   = st;
endmodule

// File: tb/pwr_fault_seq_bench.sv
`timescale 1ns/1ps
module pwr_fault_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0, shdn_n = 1'b0, irq_clr = 1'b0;
    logic       uv = 1'b0, ck = 1'b0, ot = 1'b0, oc = 1'b0;
    logic [2:0] mode = 3'b010;
    logic       sys_rst, ana_pd, resume, uv_flag;
    logic [3:0] evt;
    logic [1:0] state;

    int n_run = 0, n_fail = 0;
    bit started = 1'b0;

    always #10 clk = ~clk;

    pwr_fault_seq u_pwr_fault_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .shdn_n_i(shdn_n),
        .mode_i(mode), .irq_clr_i(irq_clr), .uv_i(uv), .clk_err_i(ck),
        .ot_i(ot), .oc_i(oc), .sys_rst_o(sys_rst), .ana_pd_o(ana_pd),
        .resume_o(resume), .evt_o(evt), .uv_flag_o(uv_flag), .state_o(state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // reference model built from the requirements: 2-stage input pipe
    logic [4:0] m_s1, m_s2;
    logic [1:0] m_st;
    logic [3:0] m_ev;
    logic       m_res, m_uv, m_arm;

    always @(posedge clk) begin : mdl
        logic [1:0] ns; logic [3:0] ev; logic res, su, dis;
        logic sh, fu, fc, ft, fo, mact, hf;
        {fo, ft, fc, fu, sh} = m_s2;
        mact = (mode == 3'b000);
        hf = fu | ft | fo;
        ns = m_st; ev = 4'd0; res = 1'b0; su = 1'b0; dis = 1'b0;
        if (!supply_ok || !sh) ns = 2'd0;
        else case (m_st)
            2'd0: ns = 2'd1;
            2'd1: if (mact && m_arm && !m_uv) begin
                      if (fu) begin ev = 4'b0001; su = 1'b1; dis = 1'b1; end
                      else if (!(fc | ft | fo)) ns = 2'd2;
                  end
            2'd2: if (hf) begin ns = 2'd1; ev = {fo, ft, fc, fu}; su = fu; dis = 1'b1; end
                  else if (fc) begin ns = 2'd3; ev = 4'b0010; end
                  else if (!mact) ns = 2'd1;
            default: if (!mact) ns = 2'd1;
                  else if (hf) begin ns = 2'd1; ev = {fo, ft, 1'b0, fu}; su = fu; dis = 1'b1; end
                  else if (!fc) begin ns = 2'd2; res = 1'b1; end
        endcase
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_st <= 2'd0; m_ev <= '0; m_res <= 1'b0;
            m_uv <= 1'b0; m_arm <= 1'b1;
        end else begin
            m_s1 <= {oc, ot, ck, uv, shdn_n};
            m_s2 <= m_s1;
            m_st <= ns; m_ev <= ev; m_res <= res;
            if (m_st == 2'd0) begin m_uv <= 1'b0; m_arm <= 1'b1; end
            else begin
                if (su) m_uv <= 1'b1; else if (irq_clr) m_uv <= 1'b0;
                if (dis) m_arm <= 1'b0;
                else if (m_st == 2'd1 && !mact && !m_uv) m_arm <= 1'b1;
            end
        end
        started <= 1'b1;
    end

    // per-cycle comparison of registered outputs with the model
    always @(negedge clk) begin
        if (started) begin
            chk("R3 model state", int'(state), int'(m_st));
            chk("R4 model evt", int'(evt), int'(m_ev));
            chk("R8 model resume", int'(resume), int'(m_res));
            chk("R6 model uv_flag", int'(uv_flag), int'(m_uv));
            chk("R3 model ana_pd", int'(ana_pd), int'(m_st != 2'd2));
        end
    end

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        cyc(3);
        chk("R1 reset sys_rst", sys_rst, 1);
        chk("R1 reset state", state, 0);
        chk("R1 reset ana_pd", ana_pd, 1);
        chk("R1 reset uv_flag", uv_flag, 0);
        chk("R1 reset evt", evt, 0);
        rst_n = 1'b1;
        cyc(2);
        supply_ok = 1'b1; #1;
        chk("R1 supply valid releases reset", sys_rst, 0);
        cyc(5);
        chk("R2 pin held keeps hwsd", state, 0);
        shdn_n = 1'b1;
        cyc(2);
        chk("R11 pin release not yet seen", state, 0);
        cyc(1);
        chk("R2 pin release to swsd", state, 1);
        mode = 3'b000; cyc(1);
        chk("R3 enter active", state, 2);
        chk("R3 analog up", ana_pd, 0);
        mode = 3'b101; cyc(1);
        chk("R10 other code is shutdown", state, 1);
        chk("R10 no event", evt, 0);
        mode = 3'b000; cyc(1);
        chk("R3 re-enter active", state, 2);
        // clock error and recovery
        ck = 1'b1; cyc(2);
        chk("R11 clock error in sync", state, 2);
        cyc(1);
        chk("R7 clock fault state", state, 3);
        chk("R7 clock event", evt, 4'b0010);
        chk("R7 analog down", ana_pd, 1);
        cyc(1);
        chk("R7 event one cycle", evt, 0);
        ck = 1'b0; cyc(3);
        chk("R8 return to active", state, 2);
        chk("R8 resume pulse", resume, 1);
        cyc(1);
        chk("R8 resume one cycle", resume, 0);
        // undervoltage in active and lockout
        uv = 1'b1; cyc(3);
        chk("R4 uv exit", state, 1);
        chk("R4 uv event", evt, 4'b0001);
        chk("R4 uv flag", uv_flag, 1);
        uv = 1'b0; cyc(4);
        chk("R6 locked with flag", state, 1);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
        chk("R6 flag cleared", uv_flag, 0);
        cyc(2);
        chk("R6 locked until mode rewrite", state, 1);
        mode = 3'b010; cyc(1);
        mode = 3'b000; cyc(1);
        chk("R6 entry after clear and rewrite", state, 2);
        // failed entry
        mode = 3'b010; cyc(1);
        uv = 1'b1; cyc(3);
        mode = 3'b000; cyc(1);
        chk("R5 failed entry stays swsd", state, 1);
        chk("R5 failed entry event", evt, 4'b0001);
        chk("R5 failed entry flag", uv_flag, 1);
        // hardware shutdown clears lockout
        shdn_n = 1'b0; uv = 1'b0; cyc(3);
        chk("R2 pin forces hwsd", state, 0);
        cyc(1);
        chk("R6 hwsd clears flag", uv_flag, 0);
        shdn_n = 1'b1; cyc(4);
        chk("R6 hwsd clears lockout", state, 2);
        // over-temperature and over-current
        ot = 1'b1; cyc(3);
        chk("R9 ot exit", state, 1);
        chk("R9 ot event", evt, 4'b0100);
        chk("R9 ot no uv flag", uv_flag, 0);
        ot = 1'b0; cyc(4);
        chk("R9 ot lockout", state, 1);
        mode = 3'b010; cyc(1); mode = 3'b000; cyc(1);
        chk("R9 ot re-entry", state, 2);
        oc = 1'b1; cyc(3);
        chk("R9 oc event", evt, 4'b1000);
        chk("R9 oc exit", state, 1);
        oc = 1'b0; cyc(3);
        mode = 3'b010; cyc(1); mode = 3'b000; cyc(1);
        chk("R9 oc re-entry", state, 2);
        // supply loss during active
        supply_ok = 1'b0; #1;
        chk("R1 immediate reset", sys_rst, 1);
        cyc(1);
        chk("R1 supply loss hwsd", state, 0);
        supply_ok = 1'b1; cyc(2);
        // random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            if (supply_ok) supply_ok = ($urandom % 200) != 0;
            else           supply_ok = ($urandom % 4) == 0;
            if (shdn_n) shdn_n = ($urandom % 150) != 0;
            else        shdn_n = ($urandom % 4) == 0;
            if (uv) uv = ($urandom % 6) != 0; else uv = ($urandom % 60) == 0;
            if (ck) ck = ($urandom % 6) != 0; else ck = ($urandom % 40) == 0;
            if (ot) ot = ($urandom % 6) != 0; else ot = ($urandom % 90) == 0;
            if (oc) oc = ($urandom % 6) != 0; else oc = ($urandom % 90) == 0;
            if (($urandom % 10) == 0) begin
                case ($urandom % 4)
                    0, 2:    mode = 3'b000;
                    1:       mode = 3'b010;
                    default: mode = 3'($urandom);
                endcase
            end
            irq_clr = ($urandom % 10) == 0;
            cyc(1);
            chk("R1 sys_rst follows supply", sys_rst, !supply_ok);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule